// File: doc/BRIEF.md
# Trace Message Serializer

This block turns program-trace requests into framed packets on a narrow trace port. A requester presents one of three message kinds: a direct branch, an error report, or an indirect branch carrying a synchronizing full target address. Each request also carries a source processor number, a count of instructions executed in sequence, a 32-bit address and an error code. Requests wait in a small queue. The serializer takes them one at a time, builds a packet that starts with a transfer code, and sends it two bits per clock. A start/end sideband line marks where each packet begins and ends.

When a request arrives and the queue has no free entry, the request is lost. The block then sends an overrun error packet ahead of everything still waiting in the queue, so the trace consumer knows that part of the history is missing. Requests with the reserved kind value are discarded.

Top module: `trace_msg_serializer`

## Requirements
- R1: After reset, and at any time no packet is being sent, `mseo` is 1 and `mdo` is 2'b00.
- R2: Each packet is a bit string sent from bit 0 upward, two bits per beat, with `mdo[0]` carrying the even bit and `mdo[1]` the odd bit. Bits 5:0 hold the transfer code and bits 9:6 hold the source processor number.
- R3: A request with `req_kind` 0 (direct branch) produces transfer code 3, followed by the 8-bit instruction count in bits 17:10. The packet is 9 beats long.
- R4: A request with `req_kind` 1 (error) produces transfer code 8, followed by the 8-bit error code in bits 17:10. The packet is 9 beats long.
- R5: A request with `req_kind` 2 (indirect branch with sync) produces transfer code 12, the instruction count in bits 17:10 and the full 32-bit target address in bits 49:18. The packet is 25 beats long.
- R6: `mseo` is 0 from the first beat of a packet through its second-to-last beat, and 1 on its last beat.
- R7: Accepted requests are sent in the order they arrived.
- R8: An instruction count above 255 on the 16-bit `req_icnt` input is sent as 255. Counts up to 255 are sent unchanged.
- R9: The queue holds 4 requests. A request that arrives while the queue is full is dropped. The next packet sent is then an error packet with error code 1, carrying the dropped request's source number, and it goes out ahead of the requests still queued.
- R10: Further drops that occur before that overrun packet starts do not add packets. Only one overrun packet is sent, and it carries the source number of the first drop.
- R11: A request with `req_kind` 3 is ignored and produces no packet.
- R12: Between two packets there is at least one idle beat (`mseo` = 1, `mdo` = 2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 direct branch, 1 error, 2 indirect branch with sync, 3 reserved |
| req_src | input | 4 | Source processor number |
| req_icnt | input | 16 | Sequential instruction count, saturated to 8 bits |
| req_addr | input | 32 | Full target address (indirect branch only) |
| req_ecode | input | 8 | Error code (error kind only) |
| mdo | output | 2 | Message data, two packet bits per beat |
| mseo | output | 1 | Start/end sideband: low while a packet is sent, high on its last beat and when idle |

## Verification
The assertions assume that `req_valid` is a single-cycle strobe whose fields are valid in the same cycle, and that reset is held for at least one clock edge. Under those assumptions the shifter starts only when it is idle, and every packet it starts carries one of the three legal codes and lengths. The stimulus drives each request for exactly one clock at the falling edge. Random bursts of one to four requests are issued only after the previous traffic has fully drained, so the queue cannot overflow by accident. Overflow is provoked only by directed bursts of six and eight back-to-back requests that start from an idle, empty state, and the order of the resulting packets is known exactly.

// File: rtl/trace_ser_pkg.sv
package trace_ser_pkg;

  localparam int TCODE_W  = 6;
  localparam int SRC_W    = 4;
  localparam int CNT_W    = 8;
  localparam int CNT_IN_W = 16;
  localparam int ADDR_W   = 32;
  localparam int ECODE_W  = 8;

  localparam int HDR_W     = TCODE_W + SRC_W;
  localparam int FRAME_W   = HDR_W + CNT_W + ADDR_W;
  localparam int MAX_BEATS = FRAME_W / 2;
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1);

  localparam logic [TCODE_W-1:0] TC_DIRECT  = TCODE_W'(3);
  localparam logic [TCODE_W-1:0] TC_ERROR   = TCODE_W'(8);
  localparam logic [TCODE_W-1:0] TC_INDSYNC = TCODE_W'(12);
  localparam logic [ECODE_W-1:0] EC_OVERRUN = ECODE_W'(1);

  typedef enum logic [1:0] {
    MK_DIRECT  = 2'd0,
    MK_ERROR   = 2'd1,
    MK_INDSYNC = 2'd2,
    MK_RSVD    = 2'd3
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e           kind;
    logic [SRC_W-1:0]    src;
    logic [CNT_W-1:0]    icnt;
    logic [ADDR_W-1:0]   addr;
    logic [ECODE_W-1:0]  ecode;
  } trace_req_t;

  localparam int REQ_W = $bits(trace_req_t);

  // Clamp a wide instruction count into the packet field.
  function automatic logic [CNT_W-1:0] sat_icnt(input logic [CNT_IN_W-1:0] raw);
    if (raw[CNT_IN_W-1:CNT_W] != '0) return '1;
    return raw[CNT_W-1:0];
  endfunction

  function automatic logic [TCODE_W-1:0] tcode_of(input msg_kind_e k);
    case (k)
      MK_ERROR:   return TC_ERROR;
      MK_INDSYNC: return TC_INDSYNC;
      default:    return TC_DIRECT;
    endcase
  endfunction

  // Packet length in two-bit beats.
  function automatic logic [BEAT_W-1:0] beats_of(input msg_kind_e k);
    case (k)
      MK_ERROR:   return BEAT_W'((HDR_W + ECODE_W) / 2);
      MK_INDSYNC: return BEAT_W'((HDR_W + CNT_W + ADDR_W) / 2);
      default:    return BEAT_W'((HDR_W + CNT_W) / 2);
    endcase
  endfunction

  // Field layout, bit 0 leaves first.
  function automatic logic [FRAME_W-1:0] build_frame(input trace_req_t r);
    logic [FRAME_W-1:0] f;
    f = '0;
    f[TCODE_W-1:0]      = tcode_of(r.kind);
    f[TCODE_W +: SRC_W] = r.src;
    if (r.kind == MK_ERROR) begin
      f[HDR_W +: ECODE_W] = r.ecode;
    end else begin
      f[HDR_W +: CNT_W] = r.icnt;
      if (r.kind == MK_INDSYNC) f[HDR_W + CNT_W +: ADDR_W] = r.addr;
    end
    return f;
  endfunction

endpackage

// File: rtl/trace_req_fifo.sv
module trace_req_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ;
  logic             do_push, do_pop;

  assign full    = (occ == OCC_W'(DEPTH));
  assign empty   = (occ == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rd_data = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  p_occ_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (occ == OCC_W'(DEPTH)));

endmodule

// File: rtl/trace_beat_shifter.sv
module trace_beat_shifter
  import trace_ser_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [BEAT_W-1:0]  nbeats,
  output logic               busy,
  output logic [1:0]         mdo,
  output logic               mseo
);
  logic [FRAME_W-1:0] shreg;
  logic [BEAT_W-1:0]  left;
  logic               last_beat;

  assign last_beat = busy && (left == BEAT_W'(1));
  assign mdo       = busy ? shreg[1:0] : 2'b00;
  assign mseo      = !busy || last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '0;
      left  <= '0;
    end else if (load && !busy) begin
      busy  <= 1'b1;
      shreg <= frame;
      left  <= nbeats;
    end else if (busy) begin
      shreg <= shreg >> 2;
      left  <= left - 1'b1;
      if (left == BEAT_W'(1)) busy <= 1'b0;
    end
  end

  p_load_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  p_end_then_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !busy);

  p_start_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (shreg[TCODE_W-1:0] == TC_DIRECT || shreg[TCODE_W-1:0] == TC_ERROR ||
                     shreg[TCODE_W-1:0] == TC_INDSYNC));

  p_start_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (left == beats_of(MK_DIRECT) || left == beats_of(MK_INDSYNC)));

endmodule

// File: rtl/trace_msg_serializer.sv
module trace_msg_serializer
  import trace_ser_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [SRC_W-1:0]    req_src,
  input  logic [CNT_IN_W-1:0] req_icnt,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [ECODE_W-1:0]  req_ecode,
  output logic [1:0]          mdo,
  output logic                mseo
);
  trace_req_t         req_in, head, ovr_req, sel_req;
  logic [REQ_W-1:0]   head_bits;
  logic               req_ok, fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic               drop_evt, ovr_pending, load, load_ovr, busy;
  logic [SRC_W-1:0]   ovr_src;
  logic [FRAME_W-1:0] frame_sel;
  logic [BEAT_W-1:0]  beats_sel;

  always_comb begin
    req_in.kind  = msg_kind_e'(req_kind);
    req_in.src   = req_src;
    req_in.icnt  = sat_icnt(req_icnt);
    req_in.addr  = req_addr;
    req_in.ecode = req_ecode;
  end

  assign req_ok    = req_valid && (req_in.kind != MK_RSVD);
  assign fifo_push = req_ok && !fifo_full;
  assign drop_evt  = req_ok && fifo_full;

  trace_req_fifo #(.DEPTH(QDEPTH), .W(REQ_W)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (fifo_push),
    .pop     (fifo_pop),
    .wr_data (req_in),
    .rd_data (head_bits),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  assign head = trace_req_t'(head_bits);

  always_comb begin
    ovr_req.kind  = MK_ERROR;
    ovr_req.src   = ovr_src;
    ovr_req.icnt  = '0;
    ovr_req.addr  = '0;
    ovr_req.ecode = EC_OVERRUN;
  end

  assign load      = !busy && (ovr_pending || !fifo_empty);
  assign load_ovr  = load && ovr_pending;
  assign fifo_pop  = load && !ovr_pending;
  assign sel_req   = ovr_pending ? ovr_req : head;
  assign frame_sel = build_frame(sel_req);
  assign beats_sel = beats_of(sel_req.kind);

  // A drop in the cycle that launches the overrun packet arms a fresh one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_pending <= 1'b0;
      ovr_src     <= '0;
    end else if (load_ovr) begin
      ovr_pending <= drop_evt;
      if (drop_evt) ovr_src <= req_src;
    end else if (drop_evt && !ovr_pending) begin
      ovr_pending <= 1'b1;
      ovr_src     <= req_src;
    end
  end

  trace_beat_shifter u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .frame  (frame_sel),
    .nbeats (beats_sel),
    .busy   (busy),
    .mdo    (mdo),
    .mseo   (mseo)
  );

  p_ovr_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovr_pending);

  p_single_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_pending && !load_ovr) |=> (ovr_pending && $stable(ovr_src)));

  p_rsvd_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |-> !fifo_push && !drop_evt);

endmodule

// File: tb/trace_msg_serializer_test.sv
module trace_msg_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXM = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [3:0]  req_src = '0;
  logic [15:0] req_icnt = '0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_ecode = '0;
  logic [1:0]  mdo;
  logic        mseo;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [63:0] got_bits [MAXM];
  int          got_len  [MAXM];
  int          got_n = 0;
  logic [63:0] exp_bits [MAXM];
  int          exp_len  [MAXM];
  string       exp_tag  [MAXM];
  int          exp_n = 0, chk_idx = 0;
  int          idle_bad = 0, gap_bad = 0;
  bit          in_msg = 0, prev_last = 0;
  logic [63:0] acc;
  int          nb;

  trace_msg_serializer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_src(req_src), .req_icnt(req_icnt), .req_addr(req_addr),
    .req_ecode(req_ecode), .mdo(mdo), .mseo(mseo)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Packet decoder, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_msg) begin
        if (mseo == 1'b0) begin
          if (prev_last) gap_bad++;
          acc = 64'(mdo);
          nb = 1;
          in_msg = 1;
          prev_last = 0;
        end else begin
          if (mdo != 2'b00) idle_bad++;
          prev_last = 0;
        end
      end else begin
        acc = acc | (64'(mdo) << (2 * nb));
        nb++;
        if (mseo) begin
          if (got_n < MAXM) begin
            got_bits[got_n] = acc;
            got_len[got_n] = nb;
          end
          got_n++;
          in_msg = 0;
          prev_last = 1;
        end
      end
    end
  end

  function automatic logic [63:0] model_frame(input int kind, input int src, input int cnt,
                                              input logic [31:0] addr, input int ecode);
    logic [63:0] v;
    int tc, c;
    tc = (kind == 0) ? 3 : (kind == 1) ? 8 : 12;
    c  = (cnt > 255) ? 255 : cnt;
    v  = 64'(tc) | (64'(src & 15) << 6);
    if (kind == 1) v = v | (64'(ecode & 255) << 10);
    else v = v | (64'(c) << 10);
    if (kind == 2) v = v | (64'(addr) << 18);
    return v;
  endfunction

  task automatic add_exp(input int kind, input int src, input int cnt, input logic [31:0] addr,
                         input int ecode, input string tag);
    exp_bits[exp_n] = model_frame(kind, src, cnt, addr, ecode);
    exp_len[exp_n]  = (kind == 2) ? 25 : 9;
    exp_tag[exp_n]  = tag;
    exp_n++;
  endtask

  task automatic drive(input int kind, input int src, input int cnt, input logic [31:0] addr,
                       input int ecode);
    req_valid = 1'b1;
    req_kind  = 2'(kind);
    req_src   = 4'(src);
    req_icnt  = 16'(cnt);
    req_addr  = addr;
    req_ecode = 8'(ecode);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send(input int kind, input int src, input int cnt, input logic [31:0] addr,
                      input int ecode, input string tag);
    drive(kind, src, cnt, addr, ecode);
    add_exp(kind, src, cnt, addr, ecode, tag);
  endtask

  task automatic drain_and_check();
    for (int k = 0; k < 600 && got_n < exp_n; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = chk_idx; i < exp_n; i++) begin
      if (i >= got_n) check(0, {exp_tag[i], " R7 missing packet"}, 64'(got_n), 64'(i + 1));
      else begin
        check(got_bits[i] == exp_bits[i], {exp_tag[i], " R2 R7 packet bits"}, got_bits[i], exp_bits[i]);
        check(got_len[i] == exp_len[i], {exp_tag[i], " R6 beat count"}, 64'(got_len[i]), 64'(exp_len[i]));
      end
    end
    check(got_n == exp_n, "R7 packet total", 64'(got_n), 64'(exp_n));
    chk_idx = exp_n;
  endtask

  function automatic string tag_of(input int kind);
    return (kind == 0) ? "R3" : (kind == 1) ? "R4" : "R5";
  endfunction

  initial begin
    int base;
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    check(mseo == 1'b1 && mdo == 2'b00, "R1 reset idle", {61'd0, mseo, mdo}, 64'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed packets of each kind
    send(0, 0, 3, 32'h0, 0, "R3");
    drain_and_check();
    send(2, 0, 3, 32'hDEAD_FACE, 0, "R5");
    drain_and_check();
    send(1, 9, 0, 32'h0, 8'h5A, "R4");
    drain_and_check();

    // Saturation of the instruction count, R8
    send(0, 2, 300, 32'h0, 0, "R8");
    send(0, 3, 255, 32'h0, 0, "R8");
    send(2, 4, 256, 32'h1234_5678, 0, "R8");
    send(0, 5, 16'hFFFF, 32'h0, 0, "R8");
    drain_and_check();

    // Reserved kind, R11
    base = got_n;
    drive(3, 7, 10, 32'hFFFF_FFFF, 1);
    repeat (40) @(negedge clk);
    check(got_n == base, "R11 reserved kind ignored", 64'(got_n), 64'(base));

    // Random bursts of up to four, never overflowing
    for (int r = 0; r < 12; r++) begin
      int len;
      len = $urandom_range(1, 4);
      for (int j = 0; j < len; j++) begin
        int k;
        k = $urandom_range(0, 2);
        send(k, $urandom_range(0, 15), $urandom_range(0, 400), $urandom, $urandom_range(0, 255), tag_of(k));
      end
      drain_and_check();
    end

    // Overflow by one, R9
    drive(0, 1, 10, 32'h0, 0);
    drive(2, 2, 20, 32'hCAFE_0001, 0);
    drive(1, 3, 0, 32'h0, 8'h77);
    drive(0, 4, 40, 32'h0, 0);
    drive(2, 5, 50, 32'hCAFE_0005, 0);
    drive(0, 6, 60, 32'h0, 0);
    add_exp(0, 1, 10, 32'h0, 0, "R9");
    add_exp(1, 6, 0, 32'h0, 1, "R9 overrun");
    add_exp(2, 2, 20, 32'hCAFE_0001, 0, "R9");
    add_exp(1, 3, 0, 32'h0, 8'h77, "R9");
    add_exp(0, 4, 40, 32'h0, 0, "R9");
    add_exp(2, 5, 50, 32'hCAFE_0005, 0, "R9");
    drain_and_check();

    // Three drops, one overrun packet, R10
    drive(0, 8, 1, 32'h0, 0);
    drive(0, 9, 2, 32'h0, 0);
    drive(0, 10, 3, 32'h0, 0);
    drive(0, 11, 4, 32'h0, 0);
    drive(0, 12, 5, 32'h0, 0);
    drive(0, 13, 6, 32'h0, 0);
    drive(2, 14, 7, 32'h0BAD_0BAD, 0);
    drive(1, 15, 0, 32'h0, 8'h33);
    add_exp(0, 8, 1, 32'h0, 0, "R10");
    add_exp(1, 13, 0, 32'h0, 1, "R10 overrun");
    add_exp(0, 9, 2, 32'h0, 0, "R10");
    add_exp(0, 10, 3, 32'h0, 0, "R10");
    add_exp(0, 11, 4, 32'h0, 0, "R10");
    add_exp(0, 12, 5, 32'h0, 0, "R10");
    drain_and_check();

    check(idle_bad == 0, "R1 idle data quiet", 64'(idle_bad), 64'd0);
    check(gap_bad == 0, "R12 idle beat between packets", 64'(gap_bad), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule